// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the condition and power-state flags of a small 8-bit processor core. Each cycle it may receive an ALU flag-update strobe carrying the operation class, the result byte and three raw carry signals from the datapath. It turns these into carry, half-carry, zero and overflow flags. For subtraction the datapath reports borrows, and the block stores their inverse, so that a set carry means that no borrow occurred.

Two further flags record the power state: power-down and watchdog time-out. They move only on power-up reset, on the watchdog-clear and halt instruction strobes, and on a watchdog expiry event. Software reads the whole byte at any time. Software may also write it through a register-file port, but a write changes only the four arithmetic flags. The two top bits are not implemented and read as zero.

Top module: `status_flag_reg`

## Requirements
- R1: The status byte is laid out as bit0 carry, bit1 half-carry, bit2 zero, bit3 overflow, bit4 power-down, bit5 time-out. Bits 6 and 7 always read 0. A synchronous active-low reset clears the whole byte to 0x00.
- R2: An add update (`alu_op`=1) sets carry to `alu_cy`, half-carry to `alu_hc`, zero to (`alu_res`==0) and overflow to `alu_msb_cin` XOR `alu_cy`.
- R3: A subtract update (`alu_op`=2) takes `alu_cy` and `alu_hc` as borrows. It sets carry to NOT `alu_cy`, half-carry to NOT `alu_hc`, zero to (`alu_res`==0) and overflow to `alu_msb_cin` XOR `alu_cy`.
- R4: A rotate-through-carry update (`alu_op`=3) loads carry with the shifted-out bit on `alu_cy` and leaves half-carry, zero and overflow unchanged.
- R5: A logic update (`alu_op`=4) changes only the zero flag and leaves carry, half-carry and overflow unchanged.
- R6: A software write (`wr_en`=1) loads bits 3..0 from `wr_data[3:0]`. Bits 7..4 of `wr_data` have no effect.
- R7: When a write and an ALU update fall in the same cycle, each flag the ALU operation updates takes the ALU value. Every other arithmetic flag takes the written value.
- R8: The halt strobe sets power-down to 1 and clears time-out to 0.
- R9: The watchdog-clear strobe clears both power-down and time-out to 0.
- R10: The watchdog expiry event sets time-out to 1 and leaves power-down unchanged.
- R11: In the same cycle, expiry wins over a clear of time-out by halt or watchdog-clear, and halt wins over watchdog-clear for power-down.
- R12: With `alu_op`=0 or any code from 5 to 7, no write and no power strobe, the byte holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| alu_op | input | 3 | ALU flag-update class: 0 none, 1 add, 2 subtract, 3 rotate, 4 logic |
| alu_res | input | DATA_W | ALU result, used for the zero flag |
| alu_cy | input | 1 | Carry (or borrow) out of the MSB, or the rotate's shifted-out bit |
| alu_hc | input | 1 | Carry (or borrow) out of the low nibble |
| alu_msb_cin | input | 1 | Carry (or borrow) into the MSB |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | STS_W | Software write data |
| halt_stb | input | 1 | Halt instruction executed |
| wdt_clr_stb | input | 1 | Watchdog-clear instruction executed |
| wdt_tmo | input | 1 | Watchdog time-out event |
| status | output | STS_W | Status byte |

## Verification
The assertions check on every cycle the following rules:
- add loads carry directly and subtract loads it inverted;
- rotate and logic operations leave the flags they do not own untouched;
- the zero flag follows the result;
- a write carrying nonzero upper bits never moves the power flags;
- each power strobe drives its flag the way the rules above state.

Only the bench scenarios show the rest. These are the per-flag merge of a write with an ALU update in the same cycle, the priority among simultaneous power strobes, the reset in mid-run, and the exact value of the whole byte after long random sequences.

// File: rtl/status_flag_pkg.sv
// Package: shared encodings for the status flag register.
// Assumes: the ALU-class encoding is fixed by the instruction decoder.
package status_flag_pkg;

    // ALU flag-update class driven by the decoder
    typedef enum logic [2:0] {
        ALU_NONE  = 3'd0,
        ALU_ADD   = 3'd1,
        ALU_SUB   = 3'd2,
        ALU_ROT   = 3'd3,
        ALU_LOGIC = 3'd4
    } alu_kind_e;

    // Bit positions inside the status byte
    localparam int BIT_C   = 0;
    localparam int BIT_AC  = 1;
    localparam int BIT_Z   = 2;
    localparam int BIT_OV  = 3;
    localparam int BIT_PD  = 4;
    localparam int BIT_TO  = 5;

    localparam int ARITH_N = 4;  // number of arithmetic flags
    localparam int USED_N  = 6;  // implemented bits

    // Arithmetic flags packed in status-bit order (c is bit 0)
    typedef struct packed {
        logic ov;
        logic z;
        logic ac;
        logic c;
    } arith_flags_t;

endpackage

// File: rtl/status_flag_decode.sv
// Module: status_flag_decode
// Purpose: turns one ALU flag strobe into candidate flag values and a
//          per-flag update mask. Purely combinational.
// Assumes: on subtraction the datapath reports borrows, not carries.
module status_flag_decode
    import status_flag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] res,
    input  logic              cy,
    input  logic              hc,
    input  logic              msb_cin,
    output arith_flags_t      val,
    output logic [ARITH_N-1:0] upd
);

    alu_kind_e kind;
    logic      res_zero;

    assign kind     = alu_kind_e'(op);
    assign res_zero = ~|res;

    // Select flag values and the mask of flags the operation owns
    always_comb begin
        val = '0;
        upd = '0;
        case (kind)
            ALU_ADD: begin
                val.c  = cy;
                val.ac = hc;
                val.z  = res_zero;
                val.ov = msb_cin ^ cy;
                upd    = 4'b1111;
            end
            ALU_SUB: begin
                val.c  = ~cy;
                val.ac = ~hc;
                val.z  = res_zero;
                val.ov = msb_cin ^ cy;
                upd    = 4'b1111;
            end
            ALU_ROT: begin
                val.c       = cy;
                upd[BIT_C]  = 1'b1;
            end
            ALU_LOGIC: begin
                val.z       = res_zero;
                upd[BIT_Z]  = 1'b1;
            end
            default: begin
                val = '0;
                upd = '0;
            end
        endcase
    end

endmodule

// File: rtl/status_arith_reg.sv
// Module: status_arith_reg
// Purpose: storage for carry, half-carry, zero and overflow. For each flag
//          an ALU update has priority over a software write.
// Assumes: synchronous active-low reset clears all flags.
module status_arith_reg
    import status_flag_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  arith_flags_t       alu_val,
    input  logic [ARITH_N-1:0] alu_upd,
    input  logic               wr_en,
    input  arith_flags_t       wr_val,
    output arith_flags_t       flags
);

    logic [ARITH_N-1:0] q;
    logic [ARITH_N-1:0] alu_bits;
    logic [ARITH_N-1:0] wr_bits;

    assign alu_bits = alu_val;
    assign wr_bits  = wr_val;
    assign flags    = arith_flags_t'(q);

    for (genvar i = 0; i < ARITH_N; i++) begin : g_flag
        // One flag: reset, then ALU, then software write, else hold
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (alu_upd[i])
                q[i] <= alu_bits[i];
            else if (wr_en)
                q[i] <= wr_bits[i];
        end
    end

endmodule

// File: rtl/status_power_reg.sv
// Module: status_power_reg
// Purpose: the protected power-down and time-out flags. Only reset and
//          the halt, watchdog-clear and expiry strobes change them.
// Assumes: the strobes are one-cycle pulses synchronous to clk.
module status_power_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_stb,
    input  logic wdt_clr_stb,
    input  logic wdt_tmo,
    output logic pd,
    output logic to
);

    // Power-down: halt sets it, watchdog-clear clears it, halt wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            pd <= 1'b0;
        else if (halt_stb)
            pd <= 1'b1;
        else if (wdt_clr_stb)
            pd <= 1'b0;
    end

    // Time-out: expiry sets it, halt or watchdog-clear clears it, expiry wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            to <= 1'b0;
        else if (wdt_tmo)
            to <= 1'b1;
        else if (halt_stb || wdt_clr_stb)
            to <= 1'b0;
    end

    AST_HALT_SETS_PD: assert property (@(posedge clk) disable iff (!rst_n)
        halt_stb |=> pd);                                     // R8
    AST_CLR_CLEARS_PD: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_clr_stb && !halt_stb) |=> !pd);                  // R9
    AST_TMO_SETS_TO: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_tmo |=> to);                                      // R10
    AST_TMO_KEEPS_PD: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_tmo && !halt_stb && !wdt_clr_stb) |=> $stable(pd)); // R10

endmodule

// File: rtl/status_flag_reg.sv
// Module: status_flag_reg (top)
// Purpose: 8-bit processor status byte. It holds the arithmetic flags fed
//          by ALU strobes and by software writes, and the protected power
//          flags fed by instruction and watchdog strobes.
// Assumes: the upper unimplemented bits read as zero, and a write only
//          reaches the arithmetic flags.
module status_flag_reg
    import status_flag_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int STS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        alu_op,
    input  logic [DATA_W-1:0] alu_res,
    input  logic              alu_cy,
    input  logic              alu_hc,
    input  logic              alu_msb_cin,
    input  logic              wr_en,
    input  logic [STS_W-1:0]  wr_data,
    input  logic              halt_stb,
    input  logic              wdt_clr_stb,
    input  logic              wdt_tmo,
    output logic [STS_W-1:0]  status
);

    localparam int PAD_W = STS_W - USED_N;

    arith_flags_t       dec_val;
    logic [ARITH_N-1:0] dec_upd;
    arith_flags_t       wr_flags;
    arith_flags_t       flags;
    logic               pd;
    logic               to;

    assign wr_flags = arith_flags_t'(wr_data[ARITH_N-1:0]);

    status_flag_decode #(.DATA_W(DATA_W)) u_decode (
        .op      (alu_op),
        .res     (alu_res),
        .cy      (alu_cy),
        .hc      (alu_hc),
        .msb_cin (alu_msb_cin),
        .val     (dec_val),
        .upd     (dec_upd)
    );

    status_arith_reg u_arith (
        .clk     (clk),
        .rst_n   (rst_n),
        .alu_val (dec_val),
        .alu_upd (dec_upd),
        .wr_en   (wr_en),
        .wr_val  (wr_flags),
        .flags   (flags)
    );

    status_power_reg u_power (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt_stb    (halt_stb),
        .wdt_clr_stb (wdt_clr_stb),
        .wdt_tmo     (wdt_tmo),
        .pd          (pd),
        .to          (to)
    );

    // Assemble the visible status byte with zero padding on top
    assign status = {{PAD_W{1'b0}}, to, pd, flags};

    AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == 3'd1) |=> (status[BIT_C] == $past(alu_cy)));     // R2
    AST_ZERO_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == 3'd1 || alu_op == 3'd2 || alu_op == 3'd4)
        |=> (status[BIT_Z] == ($past(alu_res) == '0)));            // R2
    AST_SUB_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == 3'd2) |=> (status[BIT_C] != $past(alu_cy)));     // R3
    AST_ROT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == 3'd3 && !wr_en) |=> $stable(status[BIT_OV:BIT_AC])); // R4
    AST_LOGIC_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == 3'd4 && !wr_en)
        |=> ($stable(status[BIT_OV]) && $stable(status[BIT_AC:BIT_C]))); // R5
    AST_WRITE_NO_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (|wr_data[STS_W-1:BIT_PD]) && !halt_stb && !wdt_clr_stb && !wdt_tmo)
        |=> $stable(status[STS_W-1:BIT_PD]));                      // R6

endmodule

// File: tb/sim_status_flag_reg.sv
// Bench for status_flag_reg: seeded random stimulus plus directed corners,
// compared against a bench-side model of the flag rules.
module sim_status_flag_reg;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] alu_op;
    logic [7:0] alu_res;
    logic       alu_cy, alu_hc, alu_msb_cin;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       halt_stb, wdt_clr_stb, wdt_tmo;
    logic [7:0] status;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [7:0] cur;

    always #5 clk = ~clk;

    status_flag_reg u0 (
        .clk(clk), .rst_n(rst_n), .alu_op(alu_op), .alu_res(alu_res),
        .alu_cy(alu_cy), .alu_hc(alu_hc), .alu_msb_cin(alu_msb_cin),
        .wr_en(wr_en), .wr_data(wr_data), .halt_stb(halt_stb),
        .wdt_clr_stb(wdt_clr_stb), .wdt_tmo(wdt_tmo), .status(status)
    );

    // Expected next byte from the requirement rules
    function automatic logic [7:0] model(logic [7:0] s, logic [2:0] op, logic [7:0] res,
                                         logic cy, logic hc, logic c6, logic we,
                                         logic [7:0] wd, logic h, logic cl, logic t);
        logic [7:0] n = s;
        if (we) n[3:0] = wd[3:0];                       // R6
        case (op)                                       // R7: ALU overrides
            3'd1: begin n[0] = cy;  n[1] = hc;  n[2] = (res == 0); n[3] = c6 ^ cy; end
            3'd2: begin n[0] = !cy; n[1] = !hc; n[2] = (res == 0); n[3] = c6 ^ cy; end
            3'd3: n[0] = cy;
            3'd4: n[2] = (res == 0);
            default: ;
        endcase
        if (h) n[4] = 1'b1; else if (cl) n[4] = 1'b0;
        if (t) n[5] = 1'b1; else if (h || cl) n[5] = 1'b0;
        n[7:6] = 2'b00;
        return n;
    endfunction

    function automatic string pick_tag(logic [2:0] op, logic we, logic h, logic cl, logic t);
        if ((h && cl) || (t && (h || cl))) return "R11";
        if (h) return "R8";
        if (cl) return "R9";
        if (t) return "R10";
        if (we && op >= 3'd1 && op <= 3'd4) return "R7";
        case (op)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            default: ;
        endcase
        if (we) return "R6";
        return "R12";
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: status actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Drive one cycle at a negedge and check at the following negedge
    task automatic step(string tag, logic [2:0] op, logic [7:0] res, logic cy, logic hc,
                        logic c6, logic we, logic [7:0] wd, logic h, logic cl, logic t);
        logic [7:0] exp;
        alu_op = op; alu_res = res; alu_cy = cy; alu_hc = hc; alu_msb_cin = c6;
        wr_en = we; wr_data = wd; halt_stb = h; wdt_clr_stb = cl; wdt_tmo = t;
        exp = model(cur, op, res, cy, hc, c6, we, wd, h, cl, t);
        @(negedge clk);
        check(tag, status, exp);
        cur = exp;
    endtask

    task automatic idle();
        alu_op = 3'd0; alu_res = 8'h00; alu_cy = 0; alu_hc = 0; alu_msb_cin = 0;
        wr_en = 0; wr_data = 8'h00; halt_stb = 0; wdt_clr_stb = 0; wdt_tmo = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle();
        repeat (2) @(negedge clk);
        check("R1", status, 8'h00);
        rst_n = 1'b1;
        cur = 8'h00;
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: run hung actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20011));
        @(negedge clk);
        do_reset();
        // Directed corners
        step("R2", 3'd1, 8'h00, 1, 1, 0, 0, 8'h00, 0, 0, 0);      // 0x0F
        check("R2", status, 8'h0F);
        step("R3", 3'd2, 8'h05, 0, 1, 1, 0, 8'h00, 0, 0, 0);      // no borrow
        check("R3", status, 8'h09);
        step("R4", 3'd3, 8'h00, 0, 1, 1, 0, 8'h00, 0, 0, 0);      // C only
        step("R5", 3'd4, 8'h00, 1, 1, 0, 0, 8'h00, 0, 0, 0);      // Z only
        step("R8", 3'd0, 8'h00, 0, 0, 0, 0, 8'h00, 1, 0, 0);
        step("R6", 3'd0, 8'h00, 0, 0, 0, 1, 8'hE5, 0, 0, 0);      // upper ignored
        check("R6", status, 8'h15);
        step("R10", 3'd0, 8'h00, 0, 0, 0, 0, 8'h00, 0, 0, 1);
        check("R10", status, 8'h35);
        step("R11", 3'd0, 8'h00, 0, 0, 0, 0, 8'h00, 0, 1, 1);     // TO kept, PD cleared
        check("R11", status, 8'h25);
        step("R11", 3'd0, 8'h00, 0, 0, 0, 0, 8'h00, 1, 1, 0);     // halt wins
        check("R11", status, 8'h15);
        step("R7", 3'd4, 8'h01, 0, 0, 0, 1, 8'h0F, 0, 0, 0);      // Z from ALU
        check("R7", status, 8'h1B);
        step("R9", 3'd0, 8'h00, 0, 0, 0, 0, 8'h00, 0, 1, 0);
        step("R12", 3'd6, 8'h00, 1, 1, 1, 0, 8'h00, 0, 0, 0);
        // Random mix
        for (int n = 0; n < 4000; n++) begin
            logic [2:0] op = 3'($urandom_range(0, 7));
            logic we = ($urandom_range(0, 3) == 0);
            logic h  = ($urandom_range(0, 7) == 0);
            logic cl = ($urandom_range(0, 7) == 0);
            logic t  = ($urandom_range(0, 7) == 0);
            logic [7:0] res = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
            step(pick_tag(op, we, h, cl, t), op, res, 1'($urandom), 1'($urandom),
                 1'($urandom), we, 8'($urandom), h, cl, t);
        end
        // Mid-run reset with power flags set
        step("R8", 3'd1, 8'h00, 1, 1, 0, 0, 8'h00, 1, 0, 1);
        do_reset();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule